// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits at the decode boundary of a five-stage in-order pipeline. It holds the program counter, the fetch-to-decode instruction register and the control half of the decode-to-execute register. It also decides whether the instruction now in decode must wait one cycle for a load ahead of it. A wait is needed when the instruction in execute is a load, its destination register is not register 0, and that register is one the decoding instruction actually reads as a source.

When a wait is needed, the block raises `stall` in the same cycle, combinationally from its inputs. At the next clock edge it writes an all-zero control bundle into the execute-stage register, so that slot does nothing in execute, memory and write-back. On the same edge it keeps the program counter and the fetch-to-decode register unchanged. The consuming instruction is therefore decoded again and the instruction after it is fetched again. One cycle later the loaded value can reach the consumer through forwarding, which lies outside this block.

Source matches are qualified per operand by decoded "reads" flags. A load followed by a load that names the same register in its second field therefore does not stall, because that field is a destination there, not a source.

Top module: `loaduse_stall_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` equals RESET_PC (default 0), and `ifid_instr`, `ifid_pc` and `idex_ctrl` are all zero.
- R2: `stall` is 1 when `ex_is_load` is 1, `ex_dst_reg` is nonzero, `id_reads_rs` is 1 and `id_rs` equals `ex_dst_reg`.
- R3: `stall` is 1 when `ex_is_load` is 1, `ex_dst_reg` is nonzero, `id_reads_rt` is 1 and `id_rt` equals `ex_dst_reg`.
- R4: A register match on an operand whose reads flag is 0 does not cause a stall. For example, a load whose second field equals the previous load's destination does not stall.
- R5: `stall` is 0 whenever `ex_dst_reg` is 0.
- R6: `stall` is 0 whenever `ex_is_load` is 0.
- R7: After a clock edge at which `stall` was 1, `idex_ctrl` is all zeros.
- R8: After a clock edge at which `stall` was 1, `pc_q`, `ifid_instr` and `ifid_pc` keep their previous values.
- R9: After a clock edge at which `stall` was 0, the registers take their new values. `pc_q` takes `next_pc`, `ifid_instr` takes `fetch_instr`, `ifid_pc` takes the previous `pc_q`, and `idex_ctrl` takes `id_ctrl`.
- R10: `stall` responds in the same cycle as its inputs change, with no register in its path.
- R11: For the sequence load r2; and r4,r2,r5; or r8,r2,r6; add r9,r4,r2, exactly one stall cycle, one bubble and one repeated fetch occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr | input | INSTR_W | Instruction word read at `pc_q` |
| next_pc | input | ADDR_W | Program counter value for the next fetch |
| id_rs | input | REG_AW | First source field of the instruction in decode |
| id_rt | input | REG_AW | Second field of the instruction in decode |
| id_reads_rs | input | 1 | Decode instruction reads `id_rs` as a source |
| id_reads_rt | input | 1 | Decode instruction reads `id_rt` as a source |
| id_ctrl | input | 8 | Decoded control bundle: [7] reg write, [6] mem read, [5] mem write, [4] mem-to-reg, [3] ALU source, [2] reg dest, [1:0] ALU op |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| ex_dst_reg | input | REG_AW | Destination register of the instruction in execute |
| pc_q | output | ADDR_W | Program counter register |
| ifid_instr | output | INSTR_W | Fetch-to-decode instruction register |
| ifid_pc | output | ADDR_W | Address of the instruction held in `ifid_instr` |
| idex_ctrl | output | 8 | Control bundle register for execute |
| stall | output | 1 | Load-use wait requested this cycle |

## Verification
The hardest situation to reach from the ports is the real pipeline case. There, the load's destination arrives at the execute inputs exactly one cycle after the load left decode, while the consumer is still held in decode. The bench builds that situation by acting as the surrounding pipeline. It fetches from a small program using its own model of the program counter, decodes its own model of the fetch-to-decode register, and carries each issued instruction's load flag and destination into the execute inputs one cycle later. Directed cycles with hand-set inputs then cover the register-0 case, a non-load producer and a match on an operand that is not read.

// File: rtl/lus_pkg.sv
package lus_pkg;

  typedef struct packed {
    logic       reg_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       mem_to_reg;
    logic       alu_src;
    logic       reg_dst;
    logic [1:0] alu_op;
  } lus_ctrl_t;

  localparam int unsigned LUS_CTRL_W = $bits(lus_ctrl_t);

endpackage

// File: rtl/lus_hazard_detect.sv
module lus_hazard_detect #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                            prod_is_load,
  input  logic [REG_AW-1:0]               prod_reg,
  input  logic [NUM_SRC-1:0][REG_AW-1:0]  src_reg,
  input  logic [NUM_SRC-1:0]              src_used,
  output logic                            hazard
);

  logic [NUM_SRC-1:0] src_hit;
  logic               prod_live;

  // register 0 is never a real producer
  assign prod_live = prod_is_load && (prod_reg != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = src_used[i] && (src_reg[i] == prod_reg);
  end

  assign hazard = prod_live && (|src_hit);

endmodule

// File: rtl/lus_hold_reg.sv
module lus_hold_reg #(
  parameter int unsigned   W       = 32,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/lus_ctrl_stage.sv
module lus_ctrl_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kill,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  // a killed slot enters execute with every control bit cleared
  always_comb begin
    q_nxt = d;
    if (kill) q_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/loaduse_stall_unit.sv
module loaduse_stall_unit #(
  parameter int unsigned        ADDR_W   = 32,
  parameter int unsigned        INSTR_W  = 32,
  parameter int unsigned        REG_AW   = 5,
  parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [INSTR_W-1:0]              fetch_instr,
  input  logic [ADDR_W-1:0]               next_pc,
  input  logic [REG_AW-1:0]               id_rs,
  input  logic [REG_AW-1:0]               id_rt,
  input  logic                            id_reads_rs,
  input  logic                            id_reads_rt,
  input  logic [lus_pkg::LUS_CTRL_W-1:0]  id_ctrl,
  input  logic                            ex_is_load,
  input  logic [REG_AW-1:0]               ex_dst_reg,
  output logic [ADDR_W-1:0]               pc_q,
  output logic [INSTR_W-1:0]              ifid_instr,
  output logic [ADDR_W-1:0]               ifid_pc,
  output logic [lus_pkg::LUS_CTRL_W-1:0]  idex_ctrl,
  output logic                            stall
);

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned IFID_W  = INSTR_W + ADDR_W;

  logic [NUM_SRC-1:0][REG_AW-1:0] src_reg;
  logic [NUM_SRC-1:0]             src_used;
  logic                           adv_en;
  logic [IFID_W-1:0]              ifid_d;
  logic [IFID_W-1:0]              ifid_q;

  assign src_reg  = {id_rt, id_rs};
  assign src_used = {id_reads_rt, id_reads_rs};

  lus_hazard_detect #(
    .REG_AW  (REG_AW),
    .NUM_SRC (NUM_SRC)
  ) u_detect (
    .prod_is_load (ex_is_load),
    .prod_reg     (ex_dst_reg),
    .src_reg      (src_reg),
    .src_used     (src_used),
    .hazard       (stall)
  );

  assign adv_en = !stall;

  lus_hold_reg #(
    .W       (ADDR_W),
    .RST_VAL (RESET_PC)
  ) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv_en),
    .d     (next_pc),
    .q     (pc_q)
  );

  assign ifid_d = {fetch_instr, pc_q};

  lus_hold_reg #(
    .W       (IFID_W),
    .RST_VAL ('0)
  ) u_ifid (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv_en),
    .d     (ifid_d),
    .q     (ifid_q)
  );

  assign ifid_instr = ifid_q[IFID_W-1:ADDR_W];
  assign ifid_pc    = ifid_q[ADDR_W-1:0];

  lus_ctrl_stage #(
    .W (lus_pkg::LUS_CTRL_W)
  ) u_idex (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (stall),
    .d     (id_ctrl),
    .q     (idex_ctrl)
  );

endmodule

// File: rtl/loaduse_stall_chk.sv
module loaduse_stall_chk #(
  parameter int unsigned        ADDR_W   = 32,
  parameter int unsigned        INSTR_W  = 32,
  parameter int unsigned        REG_AW   = 5,
  parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [INSTR_W-1:0]              fetch_instr,
  input  logic [ADDR_W-1:0]               next_pc,
  input  logic [REG_AW-1:0]               id_rs,
  input  logic [REG_AW-1:0]               id_rt,
  input  logic                            id_reads_rs,
  input  logic                            id_reads_rt,
  input  logic [lus_pkg::LUS_CTRL_W-1:0]  id_ctrl,
  input  logic                            ex_is_load,
  input  logic [REG_AW-1:0]               ex_dst_reg,
  input  logic [ADDR_W-1:0]               pc_q,
  input  logic [INSTR_W-1:0]              ifid_instr,
  input  logic [ADDR_W-1:0]               ifid_pc,
  input  logic [lus_pkg::LUS_CTRL_W-1:0]  idex_ctrl,
  input  logic                            stall
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pc_q == RESET_PC && ifid_instr == '0 && ifid_pc == '0 && idex_ctrl == '0));

  assert_rs_match_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst_reg != '0 && id_reads_rs && id_rs == ex_dst_reg) |-> stall);

  assert_rt_match_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst_reg != '0 && id_reads_rt && id_rt == ex_dst_reg) |-> stall);

  assert_unread_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_reads_rs && !id_reads_rt) |-> !stall);

  assert_zero_reg_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst_reg == '0) |-> !stall);

  assert_nonload_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !stall);

  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (idex_ctrl == '0));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc_q) && $stable(ifid_instr) && $stable(ifid_pc)));

  assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc_q == $past(next_pc) && ifid_instr == $past(fetch_instr)
                && ifid_pc == $past(pc_q) && idex_ctrl == $past(id_ctrl)));

endmodule

bind loaduse_stall_unit loaduse_stall_chk #(
  .ADDR_W   (ADDR_W),
  .INSTR_W  (INSTR_W),
  .REG_AW   (REG_AW),
  .RESET_PC (RESET_PC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_instr (fetch_instr),
  .next_pc     (next_pc),
  .id_rs       (id_rs),
  .id_rt       (id_rt),
  .id_reads_rs (id_reads_rs),
  .id_reads_rt (id_reads_rt),
  .id_ctrl     (id_ctrl),
  .ex_is_load  (ex_is_load),
  .ex_dst_reg  (ex_dst_reg),
  .pc_q        (pc_q),
  .ifid_instr  (ifid_instr),
  .ifid_pc     (ifid_pc),
  .idex_ctrl   (idex_ctrl),
  .stall       (stall)
);

// File: tb/loaduse_stall_unit_tb.sv
module loaduse_stall_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_instr;
  logic [31:0] next_pc;
  logic [4:0]  id_rs;
  logic [4:0]  id_rt;
  logic        id_reads_rs;
  logic        id_reads_rt;
  logic [7:0]  id_ctrl;
  logic        ex_is_load;
  logic [4:0]  ex_dst_reg;
  logic [31:0] pc_q;
  logic [31:0] ifid_instr;
  logic [31:0] ifid_pc;
  logic [7:0]  idex_ctrl;
  logic        stall;

  loaduse_stall_unit u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .next_pc(next_pc),
    .id_rs(id_rs), .id_rt(id_rt), .id_reads_rs(id_reads_rs), .id_reads_rt(id_reads_rt),
    .id_ctrl(id_ctrl), .ex_is_load(ex_is_load), .ex_dst_reg(ex_dst_reg),
    .pc_q(pc_q), .ifid_instr(ifid_instr), .ifid_pc(ifid_pc),
    .idex_ctrl(idex_ctrl), .stall(stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench-side model state
  logic [31:0] exp_pc, exp_ifid_instr, exp_ifid_pc;
  logic [7:0]  exp_idex;
  logic        exp_stall;
  logic        m_ex_load;
  logic [4:0]  m_ex_rt;
  logic        cur_is_load;
  logic [31:0] prog [16];
  int          n_stall, n_refetch, n_bubble;

  localparam logic [7:0] CTRL_RTYPE = 8'b1000_0110;
  localparam logic [7:0] CTRL_LOAD  = 8'b1101_1000;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
    return {op, rs, rt, rd, 11'd0};
  endfunction

  // environment decode of the instruction held in decode (model copy)
  task automatic decode_model();
    logic [5:0] op;
    op = exp_ifid_instr[31:26];
    id_rs = exp_ifid_instr[25:21];
    id_rt = exp_ifid_instr[20:16];
    cur_is_load = 1'b0;
    if (exp_ifid_instr == 32'd0) begin
      id_reads_rs = 0; id_reads_rt = 0; id_ctrl = 8'd0;
    end else if (op == 6'h23) begin
      id_reads_rs = 1; id_reads_rt = 0; id_ctrl = CTRL_LOAD; cur_is_load = 1'b1;
    end else begin
      id_reads_rs = 1; id_reads_rt = 1; id_ctrl = CTRL_RTYPE;
    end
  endtask

  // one clock with the inputs currently driven; compares stall, then registers
  task automatic step(input string req);
    logic [31:0] old_pc;
    #1;
    exp_stall = ex_is_load && (ex_dst_reg != 5'd0) &&
                ((id_reads_rs && id_rs == ex_dst_reg) || (id_reads_rt && id_rt == ex_dst_reg));
    chk(req, "stall (R10 same cycle)", {63'd0, stall}, {63'd0, exp_stall});
    @(posedge clk);
    old_pc = exp_pc;
    if (exp_stall) begin
      exp_idex = 8'd0;
      n_stall++;
      if (id_ctrl != 8'd0) n_bubble++;
      n_refetch++;
    end else begin
      exp_ifid_instr = fetch_instr;
      exp_ifid_pc    = old_pc;
      exp_pc         = next_pc;
      exp_idex       = id_ctrl;
    end
    m_ex_load = exp_stall ? 1'b0 : cur_is_load;
    m_ex_rt   = exp_stall ? 5'd0 : id_rt;
    #1;
    if (exp_stall) begin
      chk("R7", "idex_ctrl", {56'd0, idex_ctrl}, {56'd0, exp_idex});
      chk("R8", "pc_q", {32'd0, pc_q}, {32'd0, exp_pc});
      chk("R8", "ifid_instr", {32'd0, ifid_instr}, {32'd0, exp_ifid_instr});
      chk("R8", "ifid_pc", {32'd0, ifid_pc}, {32'd0, exp_ifid_pc});
    end else begin
      chk("R9", "idex_ctrl", {56'd0, idex_ctrl}, {56'd0, exp_idex});
      chk("R9", "pc_q", {32'd0, pc_q}, {32'd0, exp_pc});
      chk("R9", "ifid_instr", {32'd0, ifid_instr}, {32'd0, exp_ifid_instr});
      chk("R9", "ifid_pc", {32'd0, ifid_pc}, {32'd0, exp_ifid_pc});
    end
    @(negedge clk);
  endtask

  task automatic drive_prog();
    fetch_instr = (exp_pc[31:2] < 16) ? prog[exp_pc[5:2]] : 32'd0;
    next_pc     = exp_pc + 32'd4;
    decode_model();
    ex_is_load  = m_ex_load;
    ex_dst_reg  = m_ex_rt;
  endtask

  task automatic drive_raw(input logic ld, input logic [4:0] dst, input logic [4:0] rs, input logic urs,
                           input logic [4:0] rt, input logic urt, input logic [7:0] ctl);
    ex_is_load = ld; ex_dst_reg = dst;
    id_rs = rs; id_reads_rs = urs; id_rt = rt; id_reads_rt = urt; id_ctrl = ctl;
    cur_is_load = 1'b0;
    fetch_instr = 32'hA5A5_0000 ^ {27'd0, rs};
    next_pc     = exp_pc + 32'd4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) prog[i] = 32'd0;
    prog[0] = enc(6'h23, 5'd1, 5'd2, 5'd0);   // load r2
    prog[1] = enc(6'h00, 5'd2, 5'd5, 5'd4);   // and r4,r2,r5
    prog[2] = enc(6'h00, 5'd2, 5'd6, 5'd8);   // or  r8,r2,r6
    prog[3] = enc(6'h00, 5'd4, 5'd2, 5'd9);   // add r9,r4,r2
    prog[6] = enc(6'h23, 5'd3, 5'd1, 5'd0);   // load r1
    prog[7] = enc(6'h23, 5'd2, 5'd1, 5'd0);   // load r1 again, rt not a source

    rst_n = 1'b0;
    fetch_instr = 32'hFFFF_FFFF; next_pc = 32'h40;
    id_rs = 5'd3; id_rt = 5'd3; id_reads_rs = 1; id_reads_rt = 1; id_ctrl = 8'hFF;
    ex_is_load = 1; ex_dst_reg = 5'd3; cur_is_load = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pc_q", {32'd0, pc_q}, 64'd0);
    chk("R1", "ifid_instr", {32'd0, ifid_instr}, 64'd0);
    chk("R1", "ifid_pc", {32'd0, ifid_pc}, 64'd0);
    chk("R1", "idex_ctrl", {56'd0, idex_ctrl}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = 0; exp_ifid_instr = 0; exp_ifid_pc = 0; exp_idex = 0;
    m_ex_load = 0; m_ex_rt = 0;

    // program run: load-use sequence, then load followed by load on same rt
    n_stall = 0; n_refetch = 0; n_bubble = 0;
    for (int c = 0; c < 5; c++) begin
      drive_prog();
      step("R2/R3 program");
    end
    chk("R11", "stall cycles", n_stall, 1);
    chk("R11", "bubbles", n_bubble, 1);
    chk("R11", "repeated fetches", n_refetch, 1);
    n_stall = 0;
    for (int c = 0; c < 6; c++) begin
      drive_prog();
      step("R4 program");
    end
    chk("R4", "stalls for load after load", n_stall, 0);

    // directed cycles
    drive_raw(1, 5'd7, 5'd7, 1, 5'd3, 1, CTRL_RTYPE); step("R2");
    drive_raw(1, 5'd9, 5'd2, 1, 5'd9, 1, CTRL_RTYPE); step("R3");
    drive_raw(1, 5'd9, 5'd2, 1, 5'd9, 1, CTRL_RTYPE); step("R3 repeat");
    drive_raw(1, 5'd9, 5'd2, 1, 5'd9, 0, CTRL_LOAD);  step("R4");
    drive_raw(1, 5'd4, 5'd4, 0, 5'd1, 1, CTRL_RTYPE); step("R4 rs");
    drive_raw(1, 5'd0, 5'd0, 1, 5'd0, 1, CTRL_RTYPE); step("R5");
    drive_raw(0, 5'd6, 5'd6, 1, 5'd6, 1, CTRL_RTYPE); step("R6");
    drive_raw(1, 5'd31, 5'd31, 1, 5'd31, 1, CTRL_LOAD); step("R2 reg31");
    drive_raw(0, 5'd0, 5'd0, 0, 5'd0, 0, 8'd0); step("R9");

    finish_run();
  end

endmodule